// File: doc/BRIEF.md
# Bus Slave Address Match and Function Select

This block sits between a shared parallel bus and three command-driven functions inside an I/O controller: a memory reload unit, a register sender and a call combiner. It watches the active-low 16-bit bus address while a bus request is raised. When the upper twelve address bits name this controller, it reads the low four bits as a function code. It then issues a one-cycle load strobe to the chosen function's command register and returns a done acknowledge that stays up until the requester releases the bus.

The block also fans a master reset pulse out to the three functions, the bus access logic and the data path logic. All five reset outputs share one stretched pulse, so every consumer is released on the same edge. While that pulse is active, any transfer in progress is abandoned and no new transfer is accepted.

Top module: `ioc_slave_select`

## Requirements
- R1: The address lines `bus_addr_n` are active-low. A request is for this controller only when `bus_req` is high and the inverted bits 15 down to 4 equal the parameter `DEV_ID` (default 12'h3A5). An address that is not inverted is not recognised.
- R2: The function code is the inverted address bits 3 down to 0. Code 0 drives `cmd_strobe[0]` (memory reload), code 1 drives `cmd_strobe[1]` (register sender) and code 2 drives `cmd_strobe[2]` (call combiner). At most one strobe bit is ever high.
- R3: A matching request with a code from 3 to 15 raises no strobe bit. Done is still returned on the usual schedule.
- R4: The strobe is high for exactly one cycle, starting at the first rising edge that samples a matching request. The strobe fires only once per request, even if `bus_req` stays high.
- R5: `done_ack` rises on the edge after the strobe cycle. It stays high for as long as `bus_req` is high and falls at the first edge that samples `bus_req` low.
- R6: A request whose upper address bits do not match produces no strobe and no done.
- R7: The outputs `fn_rst[2:0]`, `acc_rst` and `dat_rst` rise together at the first edge that samples `mreset_n` low. They stay high for `RST_HOLD` cycles (default 2) after the last edge that samples it low, and then fall together.
- R8: While the master reset is low or its stretched pulse is active, the strobe and done stay low and no transfer is started. A transfer in progress is cancelled.
- R9: While the block reset `rst_n` is low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| bus_req | input | 1 | Bus transfer request, active high |
| bus_addr_n | input | 16 | Bus address, active low |
| mreset_n | input | 1 | Master reset pulse, active low |
| cmd_strobe | output | 3 | One-cycle command load strobe, one bit per function |
| done_ack | output | 1 | Done acknowledge returned to the bus |
| fn_rst | output | 3 | Reset to the reload, sender and combiner functions |
| acc_rst | output | 1 | Reset to the bus access logic |
| dat_rst | output | 1 | Reset to the data path logic |

## Verification
The bench holds a request high for several cycles after done. A design that re-entered its idle state too early would strobe a second time, and one that timed done from the strobe instead of from the request would drop done too soon. It sends codes 3 and 15 to catch a decoder that either sends an unused code to function 0 or withholds done for it. It also presents the address without inversion, which only a design that compares the raw bus lines would accept. It applies master reset pulses of one and three cycles, including one in the middle of a transfer. These pulses expose a stretch counter that starts from the wrong edge, a transfer that survives the reset, and a new strobe that fires before the reset pulse has ended.

// File: rtl/ioc_sel_pkg.sv
package ioc_sel_pkg;

  localparam int FN_COUNT = 3;

  typedef enum logic [1:0] {
    XS_IDLE   = 2'd0,
    XS_STROBE = 2'd1,
    XS_DONE   = 2'd2
  } xfer_state_e;

  // Maps a function code to a one-hot strobe pattern; codes without a function give zero.
  function automatic logic [FN_COUNT-1:0] code_to_sel(input logic [7:0] code);
    logic [FN_COUNT-1:0] sel;
    for (int i = 0; i < FN_COUNT; i++) begin
      sel[i] = (code == 8'(i));
    end
    return sel;
  endfunction

endpackage

// File: rtl/ioc_addr_match.sv
module ioc_addr_match
  import ioc_sel_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CODE_W = 4,
  parameter logic [ADDR_W-CODE_W-1:0] DEV_ID = 12'h3A5
) (
  input  logic                bus_req,
  input  logic [ADDR_W-1:0]   bus_addr_n,
  output logic                addr_hit,
  output logic [FN_COUNT-1:0] fn_sel
);

  logic [ADDR_W-1:0] addr_true;
  logic [CODE_W-1:0] fn_code;

  // R1: the bus lines are active-low, so invert them before comparing
  assign addr_true = ~bus_addr_n;
  assign fn_code   = addr_true[CODE_W-1:0];
  assign addr_hit  = bus_req && (addr_true[ADDR_W-1:CODE_W] == DEV_ID);
  assign fn_sel    = code_to_sel(8'(fn_code));

endmodule

// File: rtl/ioc_xfer_fsm.sv
module ioc_xfer_fsm
  import ioc_sel_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_req,
  input  logic                addr_hit,
  input  logic [FN_COUNT-1:0] fn_sel,
  input  logic                hold,
  output logic [FN_COUNT-1:0] cmd_strobe,
  output logic                done_ack
);

  xfer_state_e state;
  logic        xfer_fire;
  logic        in_strobe;

  assign xfer_fire = (state == XS_IDLE) && addr_hit && !hold;
  assign in_strobe = (state == XS_STROBE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= XS_IDLE;
      cmd_strobe <= '0;
      done_ack   <= 1'b0;
    end else if (hold) begin
      state      <= XS_IDLE;
      cmd_strobe <= '0;
      done_ack   <= 1'b0;
    end else begin
      case (state)
        XS_IDLE: begin
          if (addr_hit) begin
            state      <= XS_STROBE;
            cmd_strobe <= fn_sel;
          end
        end
        XS_STROBE: begin
          state      <= XS_DONE;
          cmd_strobe <= '0;
          done_ack   <= 1'b1;
        end
        XS_DONE: begin
          if (!bus_req) begin
            state    <= XS_IDLE;
            done_ack <= 1'b0;
          end
        end
        default: state <= XS_IDLE;
      endcase
    end
  end

  a_r2_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_strobe));

  a_r3_unused_code_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_fire && fn_sel == '0) |=> (cmd_strobe == '0));

  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_strobe) |=> (cmd_strobe == '0));

  a_r6_strobe_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_strobe) |-> $past(addr_hit));

  a_r5_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_strobe && !hold) |=> done_ack);

  a_r5_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ack && bus_req && !hold) |=> done_ack);

  a_r8_quiet_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cmd_strobe == '0 && !done_ack));

endmodule

// File: rtl/ioc_reset_fanout.sv
module ioc_reset_fanout #(
  parameter int RST_HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mreset_n,
  output logic rst_pulse
);

  localparam int CNT_W = $clog2(RST_HOLD + 1);

  logic [CNT_W-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
    end else if (!mreset_n) begin
      hold_cnt <= CNT_W'(RST_HOLD);
    end else if (hold_cnt != '0) begin
      hold_cnt <= hold_cnt - 1'b1;
    end
  end

  assign rst_pulse = (hold_cnt != '0);

  a_r7_rise_on_mreset: assert property (@(posedge clk) disable iff (!rst_n)
    !mreset_n |=> rst_pulse);

  a_r7_fall_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_pulse) |-> $past(mreset_n));

endmodule

// File: rtl/ioc_slave_select.sv
module ioc_slave_select
  import ioc_sel_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CODE_W = 4,
  parameter logic [ADDR_W-CODE_W-1:0] DEV_ID = 12'h3A5,
  parameter int RST_HOLD = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_req,
  input  logic [ADDR_W-1:0]   bus_addr_n,
  input  logic                mreset_n,
  output logic [FN_COUNT-1:0] cmd_strobe,
  output logic                done_ack,
  output logic [FN_COUNT-1:0] fn_rst,
  output logic                acc_rst,
  output logic                dat_rst
);

  logic                addr_hit;
  logic [FN_COUNT-1:0] fn_sel;
  logic                rst_pulse;
  logic                hold;

  ioc_addr_match #(
    .ADDR_W (ADDR_W),
    .CODE_W (CODE_W),
    .DEV_ID (DEV_ID)
  ) u_match (
    .bus_req    (bus_req),
    .bus_addr_n (bus_addr_n),
    .addr_hit   (addr_hit),
    .fn_sel     (fn_sel)
  );

  ioc_reset_fanout #(
    .RST_HOLD (RST_HOLD)
  ) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .mreset_n  (mreset_n),
    .rst_pulse (rst_pulse)
  );

  // R8: transfers are blocked while the master reset is low or its stretch runs
  assign hold = !mreset_n || rst_pulse;

  ioc_xfer_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .addr_hit   (addr_hit),
    .fn_sel     (fn_sel),
    .hold       (hold),
    .cmd_strobe (cmd_strobe),
    .done_ack   (done_ack)
  );

  // R7: one stretched pulse is sent to every reset consumer
  for (genvar g = 0; g < FN_COUNT; g++) begin : g_fn_rst
    assign fn_rst[g] = rst_pulse;
  end
  assign acc_rst = rst_pulse;
  assign dat_rst = rst_pulse;

  a_r9_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> (cmd_strobe == '0 && !done_ack && fn_rst == '0));

endmodule

// File: tb/ioc_slave_select_tb.sv
`timescale 1ns/1ps
module ioc_slave_select_tb;

  localparam logic [11:0] DEV = 12'h3A5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic [15:0] bus_addr_n = 16'hFFFF;
  logic        mreset_n = 1'b1;
  logic [2:0]  cmd_strobe;
  logic        done_ack;
  logic [2:0]  fn_rst;
  logic        acc_rst;
  logic        dat_rst;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;

  ioc_slave_select u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_addr_n (bus_addr_n),
    .mreset_n   (mreset_n),
    .cmd_strobe (cmd_strobe),
    .done_ack   (done_ack),
    .fn_rst     (fn_rst),
    .acc_rst    (acc_rst),
    .dat_rst    (dat_rst)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_sel(input int code);
    return (code < 3) ? 3'(1 << code) : 3'b000;
  endfunction

  function automatic logic [4:0] rst_bus();
    return {fn_rst, acc_rst, dat_rst};
  endfunction

  task automatic t_reset_state();
    @(negedge clk);
    chk(cmd_strobe == 0 && !done_ack, "R9 outputs in reset", {cmd_strobe, done_ack}, 0);
    chk(rst_bus() == 0, "R9 reset outputs low", rst_bus(), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_xfer(input int code, input int hold_cycles);
    @(negedge clk);
    bus_req = 1'b1;
    bus_addr_n = ~{DEV, 4'(code)};
    @(negedge clk);
    chk(cmd_strobe == exp_sel(code), (code < 3) ? "R2 strobe select" : "R3 no strobe for unused code",
        cmd_strobe, exp_sel(code));
    chk(!done_ack, "R5 done low in strobe cycle", done_ack, 0);
    for (int i = 0; i < hold_cycles; i++) begin
      @(negedge clk);
      chk(cmd_strobe == 0, "R4 strobe single cycle", cmd_strobe, 0);
      chk(done_ack, (code < 3) ? "R5 done held" : "R3 done for unused code", done_ack, 1);
    end
    bus_req = 1'b0;
    @(negedge clk);
    chk(!done_ack, "R5 done drops after release", done_ack, 0);
  endtask

  task automatic t_miss(input logic [15:0] addr_n, input string tag);
    @(negedge clk);
    bus_req = 1'b1;
    bus_addr_n = addr_n;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(cmd_strobe == 0 && !done_ack, tag, {cmd_strobe, done_ack}, 0);
    end
    bus_req = 1'b0;
  endtask

  task automatic t_mreset(input int low_cycles);
    @(negedge clk);
    mreset_n = 1'b0;
    for (int i = 0; i < low_cycles; i++) begin
      @(negedge clk);
      chk(rst_bus() == 5'b11111, "R7 resets high during pulse", rst_bus(), 5'b11111);
    end
    mreset_n = 1'b1;
    @(negedge clk);
    chk(rst_bus() == 5'b11111, "R7 resets stretched", rst_bus(), 5'b11111);
    @(negedge clk);
    chk(rst_bus() == 5'b00000, "R7 resets released together", rst_bus(), 0);
  endtask

  task automatic t_abort();
    @(negedge clk);
    bus_req = 1'b1;
    bus_addr_n = ~{DEV, 4'd1};
    @(negedge clk);
    @(negedge clk);
    chk(done_ack, "R5 done before abort", done_ack, 1);
    mreset_n = 1'b0;
    @(negedge clk);
    chk(!done_ack && cmd_strobe == 0, "R8 transfer cancelled", {cmd_strobe, done_ack}, 0);
    mreset_n = 1'b1;
    @(negedge clk);
    chk(!done_ack && cmd_strobe == 0, "R8 no restart in stretch", {cmd_strobe, done_ack}, 0);
    @(negedge clk);
    chk(!done_ack && cmd_strobe == 0, "R8 no restart in stretch end", {cmd_strobe, done_ack}, 0);
    bus_req = 1'b0;
    @(negedge clk);
    chk(rst_bus() == 0 && !done_ack, "R8 idle after reset", rst_bus(), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    t_reset_state();
    t_xfer(0, 1);
    t_xfer(1, 4);
    t_xfer(2, 2);
    t_xfer(3, 1);
    t_xfer(15, 2);
    t_miss(~{12'h3A4, 4'd0}, "R6 wrong device no response");
    t_miss({DEV, 4'd0}, "R1 uninverted address ignored");
    t_mreset(1);
    t_mreset(3);
    t_abort();
    t_xfer(2, 1);
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule